// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Bus Engine

This block is the bus-facing protocol engine of a small serial EEPROM. It runs on an oversampled system clock. It cleans up the SCL and SDA lines, recognises bus conditions, decodes the device select byte, and keeps an internal byte pointer. It talks to a storage back end through a plain byte interface: a one-cycle write strobe with address and data, a one-cycle read request whose data is returned one clock later, and a busy input that reflects an internal write cycle in progress. SDA is driven only as an open-drain pull-down enable.

The engine supports byte and page writes, reads from the current pointer, random reads (a byte address written, then a repeated START and a read select), and sequential reads that run through the whole array. The parameter `MEM_512` selects the larger 512-byte array. In that configuration one bit of the select byte becomes the ninth address bit instead of a strap comparison.

States: `ST_IDLE` (ignore the bus until a START), `ST_DEV` (shift in the select byte), `ST_WADR` (shift in the byte address), `ST_WDAT` (shift in write data), `ST_ACK` (pull SDA low during the ninth clock), `ST_TX` (shift a read byte out), `ST_MACK` (sample the master's acknowledge). The transitions are as follows:
- A START moves any state to `ST_DEV`, and a STOP moves any state to `ST_IDLE`.
- From `ST_DEV`, a completed byte goes to `ST_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_WADR` and `ST_WDAT` go to `ST_ACK` when a byte completes.
- `ST_ACK` goes to `ST_WADR`, `ST_WDAT` or `ST_TX` on the falling edge that ends the ninth clock.
- `ST_TX` goes to `ST_MACK` after eight bits.
- `ST_MACK` goes to `ST_TX` when the master acknowledged and to `ST_IDLE` when it did not.

Top module: `eeprom_i2c_engine`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts select-byte reception from any state and any bit position, including part-way through a byte. A STOP (SDA rising while SCL is high) returns the engine to idle with SDA released.
- R2: A select byte is acknowledged only when its bits 7..4 equal 1010 and its strap bits match. Otherwise the engine does not acknowledge and ignores the bus until the next START.
- R3: With `MEM_512`=0, select bits 3..1 must equal `strap[2:0]`. With `MEM_512`=1, select bits 3..2 must equal `strap[2:1]`, and select bit 1 is loaded into pointer bit 8 on every matching select byte. Select bit 0 is 1 for a read and 0 for a write.
- R4: In write mode, the engine pulls SDA low on the ninth clock after the select byte and after every received byte. Each data byte produces a single-cycle `wr_en` carrying the pointer and the byte.
- R5: During a write, only the low `PAGE_BITS` bits of the pointer advance after each data byte, so a write that runs past the end of a 16-byte page wraps to the start of that page.
- R6: A read select with no preceding byte address returns the byte at the current pointer. A byte address written and then followed by a repeated START and a read select returns the byte at that address.
- R7: During a read, the pointer advances by one after each byte and wraps from the last location of the whole array to 0.
- R8: On the ninth clock of a read byte the engine releases SDA. It sends another byte only when the master pulled SDA low. After a NoACK it stays released and idle.
- R9: While `busy` is high the engine does not acknowledge a matching select byte.
- R10: The engine changes its SDA pull-down only while SCL is low, after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Device address strap pins |
| busy | input | 1 | Back end is in an internal write cycle |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 8 | Write byte |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | AW | Read byte address |
| rd_data | input | 8 | Read byte, valid the cycle after `rd_req` |

## Verification
A master model on a shared wired-AND bus drives two engines, one per array size, with different straps. Select bytes with the wrong type nibble or the wrong strap bits confirm that only the addressed engine answers. Writes that cross a page boundary distinguish page wrap from a linear increment. Random, current-pointer and sequential reads across the top of the array distinguish full-array wrap from page wrap, and show that select bit 1 reaches pointer bit 8 in the large configuration. A START inserted after three bits, a select byte offered while `busy` is high, and a NoACK followed by STOP cover abort, acknowledge polling and release.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADR,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = $clog2(WIN + 1);

    logic [SYNC_STAGES-1:0] sync_r;
    logic [WIN-1:0]         hist_r;
    logic [CW-1:0]          ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_r <= '1;
            hist_r <= '1;
            q      <= 1'b1;
        end else begin
            sync_r <= {sync_r[SYNC_STAGES-2:0], d};
            hist_r <= {hist_r[WIN-2:0], sync_r[SYNC_STAGES-1]};
            q      <= (ones > CW'(WIN / 2));
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIN; i++) begin
            ones = ones + CW'(hist_r[i]);
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign start_ev = scl & scl_q & sda_q & ~sda;
    assign stop_ev  = scl & scl_q & ~sda_q & sda;
    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;

endmodule

// File: rtl/eeprom_i2c_engine.sv
module eeprom_i2c_engine
    import eeprom_i2c_pkg::*;
#(
    parameter int MEM_512   = 0,
    parameter int PAGE_BITS = 4,
    parameter int FILT_WIN  = 3,
    localparam int AW       = (MEM_512 != 0) ? 9 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic [2:0]    strap,
    input  logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    logic scl_f, sda_f;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    i2c_line_filter #(.SYNC_STAGES(2), .WIN(FILT_WIN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_f));
    i2c_line_filter #(.SYNC_STAGES(2), .WIN(FILT_WIN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_f));

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall));

    eng_state_t    state, state_nx, after_ack;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg, txsh, rdbuf;
    logic [AW-1:0] ptr, ptr_sel, ptr_pg;
    logic          m_acked, rd_pend;
    logic          strap_ok, dev_hit, byte_done;

    // Array-size variant: strap comparison and ninth address bit
    if (MEM_512 != 0) begin : g_big
        assign strap_ok = (shreg[3:2] == strap[2:1]);
        assign ptr_sel  = {shreg[1], ptr[7:0]};
    end else begin : g_small
        assign strap_ok = (shreg[3:1] == strap);
        assign ptr_sel  = ptr;
    end

    assign dev_hit   = (shreg[7:4] == DEV_TYPE) && strap_ok && !busy;
    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign ptr_pg    = {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_DEV;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_DEV:  if (byte_done) state_nx = dev_hit ? ST_ACK : ST_IDLE;
                ST_WADR: if (byte_done) state_nx = ST_ACK;
                ST_WDAT: if (byte_done) state_nx = ST_ACK;
                ST_ACK:  if (scl_fall)  state_nx = after_ack;
                ST_TX:   if (byte_done) state_nx = ST_MACK;
                ST_MACK: if (scl_fall)  state_nx = m_acked ? ST_TX : ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txsh      <= '0;
            rdbuf     <= '0;
            ptr       <= '0;
            after_ack <= ST_IDLE;
            m_acked   <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_req    <= 1'b0;
            rd_addr   <= '0;
        end else begin
            wr_en   <= 1'b0;
            rd_req  <= 1'b0;
            rd_pend <= rd_req;
            if (rd_pend) rdbuf <= rd_data;

            if (start_ev || stop_ev) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_f};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (state == ST_DEV) begin
                                if (dev_hit) begin
                                    sda_oe <= 1'b1;
                                    if (shreg[0]) begin
                                        after_ack <= ST_TX;
                                        rd_req    <= 1'b1;
                                        rd_addr   <= ptr_sel;
                                        ptr       <= ptr_sel + 1'b1;
                                    end else begin
                                        after_ack <= ST_WADR;
                                        ptr       <= ptr_sel;
                                    end
                                end
                            end else if (state == ST_WADR) begin
                                sda_oe    <= 1'b1;
                                ptr[7:0]  <= shreg;
                                after_ack <= ST_WDAT;
                            end else begin
                                sda_oe    <= 1'b1;
                                wr_en     <= 1'b1;
                                wr_addr   <= ptr;
                                wr_data   <= shreg;
                                ptr       <= ptr_pg;
                                after_ack <= ST_WDAT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (after_ack == ST_TX) begin
                                txsh   <= rdbuf;
                                sda_oe <= ~rdbuf[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_acked <= ~sda_f;
                            if (!sda_f) begin
                                rd_req  <= 1'b1;
                                rd_addr <= ptr;
                                ptr     <= ptr + 1'b1;
                            end
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (m_acked) begin
                                txsh   <= rdbuf;
                                sda_oe <= ~rdbuf[7];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_engine_chk.sv
module eeprom_i2c_engine_chk
    import eeprom_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       rd_req,
    input logic       stop_ev,
    input eng_state_t state
);
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                   // R4
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);                                 // R6
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);                           // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);                                // R1
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);                     // R8
    AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> !wr_en);                        // R4

endmodule

bind eeprom_i2c_engine eeprom_i2c_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
    .wr_en(wr_en), .rd_req(rd_req), .stop_ev(stop_ev), .state(state));

// File: tb/tb_eeprom_i2c_engine.sv
module tb_eeprom_i2c_engine;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl = 1'b1, m_sda = 1'b1;
    logic oe0, oe1, busy0 = 1'b0, busy1 = 1'b0;
    wire  sda_bus = ~(~m_sda | oe0 | oe1);

    logic       we0, rq0, we1, rq1;
    logic [7:0] wa0, ra0, wd0, rd0, wd1, rd1;
    logic [8:0] wa1, ra1;
    logic [7:0] mem0 [256];
    logic [7:0] mem1 [512];

    int checks = 0, fails = 0, viol = 0;
    logic prev_oe0 = 1'b0, prev_oe1 = 1'b0;

    eeprom_i2c_engine dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(oe0),
        .strap(3'b000), .busy(busy0), .wr_en(we0), .wr_addr(wa0), .wr_data(wd0),
        .rd_req(rq0), .rd_addr(ra0), .rd_data(rd0));

    eeprom_i2c_engine #(.MEM_512(1)) dut512 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(oe1),
        .strap(3'b011), .busy(busy1), .wr_en(we1), .wr_addr(wa1), .wr_data(wd1),
        .rd_req(rq1), .rd_addr(ra1), .rd_data(rd1));

    function automatic logic [7:0] init0(int i); return 8'(i * 37 + 11); endfunction
    function automatic logic [7:0] init1(int i); return 8'(i * 53 + 5);  endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem0[i] = init0(i);
        for (int i = 0; i < 512; i++) mem1[i] = init1(i);
    end

    always @(posedge clk) begin
        if (we0) mem0[wa0] <= wd0;
        if (rq0) rd0 <= mem0[ra0];
        if (we1) mem1[wa1] <= wd1;
        if (rq1) rd1 <= mem1[ra1];
        prev_oe0 <= oe0;
        prev_oe1 <= oe1;
        if (rst_n && scl && (oe0 !== prev_oe0 || oe1 !== prev_oe1)) viol++;
    end

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mbit(input logic b, output logic seen);
        m_sda = b; wq(Q);
        scl = 1'b1; wq(Q);
        seen = sda_bus; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) mbit(b[i], s);
        mbit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            mbit(1'b1, s);
            d[i] = s;
        end
        mbit(~ack_it, s);
    endtask

    task automatic t_reset();
        check("R1 reset sda_oe", 16'(oe0), 16'h0);
        check("R4 reset wr_en", 16'(we0), 16'h0);
    endtask

    task automatic t_bad_select();
        logic a;
        bus_start(); send_byte(8'hB0, a); bus_stop();
        check("R2 wrong type nibble nack", 16'(a), 16'h0);
        bus_start(); send_byte(8'hA2, a); bus_stop();
        check("R2 R3 wrong strap nack", 16'(a), 16'h0);
    endtask

    task automatic t_write();
        logic a0, a1, a2, a3, a4;
        bus_start();
        send_byte(8'hA0, a0); send_byte(8'h10, a1);
        send_byte(8'h11, a2); send_byte(8'h22, a3); send_byte(8'h33, a4);
        bus_stop();
        check("R4 acks", 16'({a0, a1, a2, a3, a4}), 16'h1F);
        check("R4 byte 0x10", 16'(mem0[8'h10]), 16'h11);
        check("R4 byte 0x12", 16'(mem0[8'h12]), 16'h33);
    endtask

    task automatic t_page_wrap();
        logic a;
        bus_start();
        send_byte(8'hA0, a); send_byte(8'h1E, a);
        send_byte(8'hC1, a); send_byte(8'hC2, a);
        send_byte(8'hC3, a); send_byte(8'hC4, a);
        bus_stop();
        check("R5 0x1F", 16'(mem0[8'h1F]), 16'hC2);
        check("R5 wrap 0x10", 16'(mem0[8'h10]), 16'hC3);
        check("R5 wrap 0x11", 16'(mem0[8'h11]), 16'hC4);
        check("R5 no spill 0x20", 16'(mem0[8'h20]), 16'(init0(8'h20)));
    endtask

    task automatic t_random_current();
        logic a; logic [7:0] d;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h40, a);
        bus_start(); send_byte(8'hA1, a);
        check("R6 read select ack", 16'(a), 16'h1);
        recv_byte(1'b0, d); bus_stop();
        check("R6 random read", 16'(d), 16'(init0(8'h40)));
        bus_start(); send_byte(8'hA1, a); recv_byte(1'b0, d); bus_stop();
        check("R6 current read", 16'(d), 16'(init0(8'h41)));
    endtask

    task automatic t_seq_wrap();
        logic a; logic [7:0] d0, d1, d2;
        bus_start(); send_byte(8'hA0, a); send_byte(8'hFE, a);
        bus_start(); send_byte(8'hA1, a);
        recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
        wq(Q);
        check("R8 released after NoACK", 16'(oe0), 16'h0);
        bus_stop();
        check("R7 seq 0xFE", 16'(d0), 16'(init0(8'hFE)));
        check("R7 seq 0xFF", 16'(d1), 16'(init0(8'hFF)));
        check("R7 seq wrap 0x00", 16'(d2), 16'(init0(0)));
    endtask

    task automatic t_busy_poll();
        logic a;
        busy0 = 1'b1;
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check("R9 busy nack", 16'(a), 16'h0);
        busy0 = 1'b0;
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check("R9 ack after busy", 16'(a), 16'h1);
    endtask

    task automatic t_abort();
        logic a, s;
        bus_start();
        mbit(1'b1, s); mbit(1'b0, s); mbit(1'b1, s);
        bus_start(); send_byte(8'hA0, a);
        check("R1 restart mid-byte ack", 16'(a), 16'h1);
        send_byte(8'h50, a); send_byte(8'h99, a); bus_stop();
        check("R1 write after restart", 16'(mem0[8'h50]), 16'h99);
    endtask

    task automatic t_big_array();
        logic a; logic [7:0] d0, d1;
        bus_start(); send_byte(8'hA6, a); send_byte(8'h05, a);
        send_byte(8'h77, a); bus_stop();
        check("R3 bit 8 write", 16'(mem1[9'h105]), 16'h77);
        check("R3 low half untouched", 16'(mem1[9'h005]), 16'(init1(5)));
        bus_start(); send_byte(8'hA6, a); send_byte(8'hFF, a);
        bus_start(); send_byte(8'hA7, a);
        recv_byte(1'b1, d0); recv_byte(1'b0, d1); bus_stop();
        check("R3 R7 read 0x1FF", 16'(d0), 16'(init1(511)));
        check("R7 wrap array end", 16'(d1), 16'(init1(0)));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wq(4);
        t_reset();
        t_bad_select();
        t_write();
        t_page_wrap();
        t_random_current();
        t_seq_wrap();
        t_busy_poll();
        t_abort();
        t_big_array();
        check("R10 SDA change while SCL high", 16'(viol), 16'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule